// File: doc/BRIEF.md
# Buffer Access Validator

This block decides whether a byte buffer can be used for a given operation. The buffer is given as a start address, a byte size, a read/write flag and a kernel/user flag. A single-cycle `start` pulse launches the check. The block first widens the buffer outward to whole protection granules. It then walks that range one granule at a time, sending one probe per granule on a request port to an external region lookup. The lookup answers each probe with a response word. The block takes a validity field and an access-rights code from that word and tests the code against the read-allowed or write-allowed set for the requested privilege. The walk stops at the first granule that fails. At the end the block raises `done` for one cycle, and `pass` holds the verdict until the next accepted start.

The controller is a four-state machine. The states are IDLE, REQUEST, AWAIT and FINISH.
- IDLE goes to REQUEST on an accepted start with a non-zero size, or straight to FINISH when the size is zero.
- REQUEST holds the probe until the lookup accepts it, then goes to AWAIT.
- AWAIT waits for the response. It goes back to REQUEST while granules remain and the current one is allowed. It goes to FINISH on a failing granule or after the last granule.
- FINISH pulses `done` and returns to IDLE.

Top module: `buf_access_checker`

## Requirements
- R1: The first probe address is the buffer start address rounded down to a multiple of the granule size (default 32 bytes, so address bits [4:0] are zero on every probe).
- R2: For a non-zero size, a passing check issues exactly ceil((size + start mod 32) / 32) probes. The addresses rise by 32 each time and wrap modulo 2^32.
- R3: A start with size zero issues no probe. It raises `done` with `pass`=1 on the cycle after the start is sampled.
- R4: A response whose validity field, bits [1:0], is zero fails the check, whatever its rights code.
- R5: The rights code sits in response bits [11:8]. Codes: 0 none, 1 kernel read, 2 kernel read+exec, 3 kernel read/write, 4 kernel read/write/exec, 5 write-only both modes, 6 kernel rw + user rwx, 7 kernel rw + user read, 8 kernel rwx + user rx, 9 read both, 10 read+exec both, 11 read/write both, 12 rwx both, 13 kernel exec only, 14 user exec only, 15 none. A kernel read passes on codes 1,2,3,4,6,7,8,9,10,11,12. A kernel write passes on codes 3,4,5,6,7,8,11,12.
- R6: A user read passes only on codes 6 through 12. A user write passes only on codes 5,6,11,12. The kernel-only codes 1 to 4 therefore fail in user mode.
- R7: After the first failing response, no further probe is issued. `done` follows on the next cycle with `pass`=0.
- R8: At most one probe is outstanding. `probe_valid` and `probe_addr` hold steady until `probe_ready`, and no new request appears until the response has arrived.
- R9: A start while the block is busy is ignored. The running check continues with its original buffer, operation and privilege.
- R10: `done` is high for exactly one cycle. `pass` keeps its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, honoured only when idle |
| buf_addr | input | 32 | Buffer start byte address |
| buf_size | input | 32 | Buffer length in bytes |
| is_write | input | 1 | 1 checks write access, 0 read access |
| is_user | input | 1 | 1 checks user privilege, 0 kernel |
| busy | output | 1 | High from an accepted start until back in IDLE |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Verdict, held until the next accepted start |
| probe_valid | output | 1 | Probe request valid |
| probe_ready | input | 1 | Lookup accepts the probe |
| probe_addr | output | 32 | Granule-aligned probe address |
| resp_valid | input | 1 | Lookup response valid, one cycle |
| resp_data | input | 32 | Lookup result: validity [1:0], rights [11:8] |

## Verification
The bench targets these corner cases:
- An unaligned start whose few bytes spill into the next granule. A design that rounded the size without adding the offset would miss the second probe.
- A zero size at an unaligned address. A design that did not special-case it would issue a spurious probe.
- An invalid entry or a forbidden code part-way through the buffer. A design that kept walking would show extra probes in the log; one that ignored the validity field would report pass.
- A kernel-only code checked in user mode. Swapped or merged permission sets give the wrong verdict.
- A second start fired mid-walk. A design that accepted it would jump to another address sequence.

// File: rtl/buf_chk_pkg.sv
package buf_chk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQUEST,
        ST_AWAIT,
        ST_FINISH
    } chk_state_e;

    localparam int RIGHTS_CODE_W = 4;
    localparam int RIGHTS_CODES  = 1 << RIGHTS_CODE_W;

endpackage

// File: rtl/buf_span_calc.sv
module buf_span_calc #(
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 32,
    parameter int GRAN_LOG2 = 5,
    localparam int SUM_W    = SIZE_W + 2,
    localparam int CNT_W    = SUM_W - GRAN_LOG2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic [ADDR_W-1:0] base,
    output logic [CNT_W-1:0]  count
);
    localparam int GRAN_BYTES = 1 << GRAN_LOG2;

    logic [SUM_W-1:0] span_sum;
    logic             unused_low;

    always_comb begin
        span_sum = SUM_W'(size) + SUM_W'(addr[GRAN_LOG2-1:0]) + SUM_W'(GRAN_BYTES - 1);
        count    = span_sum[SUM_W-1:GRAN_LOG2];
        base     = {addr[ADDR_W-1:GRAN_LOG2], {GRAN_LOG2{1'b0}}};
    end

    assign unused_low = ^span_sum[GRAN_LOG2-1:0];

endmodule

// File: rtl/buf_rights_decode.sv
module buf_rights_decode
    import buf_chk_pkg::*;
#(
    parameter int RESP_W     = 32,
    parameter int VALID_LSB  = 0,
    parameter int VALID_W    = 2,
    parameter int RIGHTS_LSB = 8,
    parameter logic [RIGHTS_CODES-1:0] KERN_RD_OK = 16'h1FDE,
    parameter logic [RIGHTS_CODES-1:0] KERN_WR_OK = 16'h19F8,
    parameter logic [RIGHTS_CODES-1:0] USER_RD_OK = 16'h1FC0,
    parameter logic [RIGHTS_CODES-1:0] USER_WR_OK = 16'h1860
) (
    input  logic [RESP_W-1:0] resp,
    input  logic              is_write,
    input  logic              is_user,
    output logic              allowed
);
    logic [RIGHTS_CODE_W-1:0] code;
    logic                     entry_hit;
    logic [RIGHTS_CODES-1:0]  sel_set;
    logic                     unused_resp;

    always_comb begin
        code      = resp[RIGHTS_LSB +: RIGHTS_CODE_W];
        entry_hit = |resp[VALID_LSB +: VALID_W];
        unique case ({is_user, is_write})
            2'b00:   sel_set = KERN_RD_OK;
            2'b01:   sel_set = KERN_WR_OK;
            2'b10:   sel_set = USER_RD_OK;
            default: sel_set = USER_WR_OK;
        endcase
        allowed = entry_hit && sel_set[code];
    end

    assign unused_resp = ^resp;

    // R4: an entry without validity bits never grants access
    always_comb begin
        assert_invalid_denied_R4: assert (entry_hit || !allowed);
    end

endmodule

// File: rtl/buf_access_checker.sv
module buf_access_checker
    import buf_chk_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 32,
    parameter int RESP_W     = 32,
    parameter int GRAN_LOG2  = 5,
    parameter int VALID_LSB  = 0,
    parameter int VALID_W    = 2,
    parameter int RIGHTS_LSB = 8,
    parameter logic [15:0] KERN_RD_OK = 16'h1FDE,
    parameter logic [15:0] KERN_WR_OK = 16'h19F8,
    parameter logic [15:0] USER_RD_OK = 16'h1FC0,
    parameter logic [15:0] USER_WR_OK = 16'h1860
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] buf_addr,
    input  logic [SIZE_W-1:0] buf_size,
    input  logic              is_write,
    input  logic              is_user,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              probe_valid,
    input  logic              probe_ready,
    output logic [ADDR_W-1:0] probe_addr,
    input  logic              resp_valid,
    input  logic [RESP_W-1:0] resp_data
);
    localparam int GRAN_BYTES = 1 << GRAN_LOG2;
    localparam int CNT_W      = SIZE_W + 2 - GRAN_LOG2;

    chk_state_e        state, nxt_state;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  remain;
    logic              wr_q, user_q, pass_q;
    logic [ADDR_W-1:0] span_base;
    logic [CNT_W-1:0]  span_cnt;
    logic              gran_ok;
    logic              size_zero;
    logic              last_gran;

    buf_span_calc #(
        .ADDR_W   (ADDR_W),
        .SIZE_W   (SIZE_W),
        .GRAN_LOG2(GRAN_LOG2)
    ) u_span (
        .addr (buf_addr),
        .size (buf_size),
        .base (span_base),
        .count(span_cnt)
    );

    buf_rights_decode #(
        .RESP_W    (RESP_W),
        .VALID_LSB (VALID_LSB),
        .VALID_W   (VALID_W),
        .RIGHTS_LSB(RIGHTS_LSB),
        .KERN_RD_OK(KERN_RD_OK),
        .KERN_WR_OK(KERN_WR_OK),
        .USER_RD_OK(USER_RD_OK),
        .USER_WR_OK(USER_WR_OK)
    ) u_decode (
        .resp    (resp_data),
        .is_write(wr_q),
        .is_user (user_q),
        .allowed (gran_ok)
    );

    assign size_zero = (buf_size == '0);
    assign last_gran = (remain == CNT_W'(1));

    // next-state logic
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE:    if (start) nxt_state = size_zero ? ST_FINISH : ST_REQUEST;
            ST_REQUEST: if (probe_ready) nxt_state = ST_AWAIT;
            ST_AWAIT:   if (resp_valid) nxt_state = (!gran_ok || last_gran) ? ST_FINISH : ST_REQUEST;
            ST_FINISH:  nxt_state = ST_IDLE;
            default:    nxt_state = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
            wr_q     <= 1'b0;
            user_q   <= 1'b0;
            pass_q   <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                cur_addr <= span_base;
                remain   <= span_cnt;
                wr_q     <= is_write;
                user_q   <= is_user;
                pass_q   <= size_zero;
            end else if (state == ST_AWAIT && resp_valid) begin
                if (!gran_ok) begin
                    pass_q <= 1'b0;
                end else if (last_gran) begin
                    pass_q <= 1'b1;
                end else begin
                    cur_addr <= cur_addr + ADDR_W'(GRAN_BYTES);
                    remain   <= remain - CNT_W'(1);
                end
            end
        end
    end

    // outputs
    always_comb begin
        probe_valid = (state == ST_REQUEST);
        probe_addr  = cur_addr;
        busy        = (state != ST_IDLE);
        done        = (state == ST_FINISH);
        pass        = pass_q;
    end

    assert_probe_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |-> (probe_addr[GRAN_LOG2-1:0] == '0));

    assert_zero_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && size_zero) |=> (done && pass));

    assert_stop_on_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AWAIT && resp_valid && !gran_ok) |=> (done && !pass && !probe_valid));

    assert_probe_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_valid && !probe_ready) |=> (probe_valid && $stable(probe_addr)));

    assert_single_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_valid && probe_ready) |=> !probe_valid);

    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != ST_FINISH) |=> ($stable(wr_q) && $stable(user_q)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_pass_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(pass));

endmodule

// File: tb/buf_access_checker_test.sv
module buf_access_checker_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] buf_addr;
    logic [31:0] buf_size;
    logic        is_write;
    logic        is_user;
    logic        busy, done, pass;
    logic        probe_valid;
    logic        probe_ready;
    logic [31:0] probe_addr;
    logic        resp_valid;
    logic [31:0] resp_data;

    always #4 clk = ~clk;

    buf_access_checker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .buf_addr(buf_addr),
        .buf_size(buf_size), .is_write(is_write), .is_user(is_user),
        .busy(busy), .done(done), .pass(pass), .probe_valid(probe_valid),
        .probe_ready(probe_ready), .probe_addr(probe_addr),
        .resp_valid(resp_valid), .resp_data(resp_data)
    );

    int checks = 0;
    int errors = 0;

    // lookup model state
    logic [3:0]  m_code;
    bit          m_bad_en;
    logic [31:0] m_bad_addr;
    logic [3:0]  m_bad_code;
    logic [1:0]  m_bad_valid;

    logic [31:0] log_addr [64];
    int          n_log;
    int          lat_cnt;
    logic [31:0] cap_addr;

    function automatic logic [31:0] model_resp(input logic [31:0] a);
        logic [3:0] c;
        logic [1:0] v;
        c = m_code;
        v = 2'b01;
        if (m_bad_en && a == m_bad_addr) begin
            c = m_bad_code;
            v = m_bad_valid;
        end
        return {a[31:12] ^ 20'hA5A5A, c, 6'h2A ^ a[7:2], v};
    endfunction

    function automatic bit allowed(input logic [3:0] c, input bit wr, input bit usr);
        if (usr) begin
            if (wr) return c inside {4'd5, 4'd6, 4'd11, 4'd12};
            return c inside {4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12};
        end
        if (wr) return c inside {4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd11, 4'd12};
        return c inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12};
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // lookup responder
    initial begin
        probe_ready = 1'b0;
        resp_valid  = 1'b0;
        resp_data   = '0;
        lat_cnt     = 0;
        n_log       = 0;
        forever begin
            @(negedge clk);
            resp_valid = 1'b0;
            if (lat_cnt > 0) begin
                lat_cnt--;
                probe_ready = 1'b0;
                if (lat_cnt == 0) begin
                    resp_valid = 1'b1;
                    resp_data  = model_resp(cap_addr);
                end
            end else begin
                probe_ready = ($urandom % 4) != 0;
                if (probe_valid && probe_ready) begin
                    cap_addr = probe_addr;
                    if (n_log < 64) log_addr[n_log] = probe_addr;
                    n_log++;
                    lat_cnt = 1 + ($urandom % 3);
                end
            end
        end
    end

    task automatic run(input logic [31:0] a, input logic [31:0] s, input bit wr, input bit usr,
                       input bit poke, input string req);
        longint      n;
        int          exp_cnt;
        bit          exp_pass;
        int          cyc;
        int          bad;
        logic [31:0] base;
        logic [31:0] r;
        base     = {a[31:5], 5'd0};
        n        = (s == 0) ? 0 : ((longint'(a[4:0]) + longint'(s) + 31) >> 5);
        exp_cnt  = int'(n);
        exp_pass = 1'b1;
        for (int i = 0; i < n; i++) begin
            r = model_resp(base + 32'(32 * i));
            if (r[1:0] == 2'b00 || !allowed(r[11:8], wr, usr)) begin
                exp_cnt  = i + 1;
                exp_pass = 1'b0;
                break;
            end
        end
        @(negedge clk);
        n_log    = 0;
        start    = 1'b1;
        buf_addr = a;
        buf_size = s;
        is_write = wr;
        is_user  = usr;
        @(negedge clk);
        start = 1'b0;
        cyc   = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 2) begin
                start    = 1'b1;
                buf_addr = a ^ 32'h0001_0000;
                buf_size = 32'd1;
                is_write = !wr;
                is_user  = !usr;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(req, "completion", done, 1);
        if (s == 0) chk("R3", "zero-size latency", cyc, 0);
        chk(req, "verdict", pass, exp_pass);
        chk(req, "probe count", n_log, exp_cnt);
        bad = 0;
        for (int i = 0; i < exp_cnt && i < n_log && i < 64; i++)
            if (log_addr[i] != base + 32'(32 * i)) bad++;
        chk("R1 R2", "probe address mismatches", bad, 0);
        @(negedge clk);
        chk("R10", "done pulse width", done, 0);
        chk("R10", "verdict held", pass, exp_pass);
    endtask

    // watchdog
    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; start = 1'b0; buf_addr = '0; buf_size = '0;
        is_write = 1'b0; is_user = 1'b0;
        m_code = 4'd12; m_bad_en = 1'b0; m_bad_addr = '0; m_bad_code = '0; m_bad_valid = '0;
        repeat (4) @(negedge clk);
        chk("R10", "reset busy", busy, 0);
        chk("R10", "reset done", done, 0);
        chk("R10", "reset pass", pass, 0);
        chk("R8", "reset probe_valid", probe_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: zero size at an unaligned address
        run(32'h0000_1003, 32'd0, 1'b0, 1'b0, 1'b0, "R3");
        // R1 R2: exactly one aligned granule
        run(32'h0000_0100, 32'd32, 1'b0, 1'b0, 1'b0, "R2");
        // R2: two bytes straddling a granule edge
        run(32'h0000_011F, 32'd2, 1'b1, 1'b1, 1'b0, "R2");
        // R4 R7: invalid entry at the second granule
        m_bad_en = 1'b1; m_bad_addr = 32'h0000_0220; m_bad_code = 4'd12; m_bad_valid = 2'b00;
        run(32'h0000_0200, 32'd128, 1'b0, 1'b0, 1'b0, "R4 R7");
        m_bad_en = 1'b0;
        // R6 vs R5: kernel read/write code
        m_code = 4'd3;
        run(32'h0000_4000, 32'd64, 1'b1, 1'b1, 1'b0, "R6");
        run(32'h0000_4000, 32'd64, 1'b1, 1'b0, 1'b0, "R5");
        m_code = 4'd9;
        run(32'h0000_4010, 32'd40, 1'b0, 1'b1, 1'b0, "R6");
        m_code = 4'd2;
        run(32'h0000_4010, 32'd40, 1'b0, 1'b1, 1'b0, "R6");
        m_code = 4'd13;
        run(32'h0000_4010, 32'd40, 1'b0, 1'b0, 1'b0, "R5");
        m_code = 4'd5;
        run(32'h0000_5000, 32'd10, 1'b0, 1'b0, 1'b0, "R5");
        run(32'h0000_5000, 32'd10, 1'b1, 1'b1, 1'b0, "R6");
        // R2: wrap at the top of the address space
        m_code = 4'd12;
        run(32'hFFFF_FFF0, 32'd40, 1'b0, 1'b0, 1'b0, "R2");
        // R9: second start fired mid-walk
        run(32'h0000_8004, 32'd220, 1'b0, 1'b0, 1'b1, "R9");

        // random mix
        for (int k = 0; k < 200; k++) begin
            logic [31:0] a;
            logic [31:0] s;
            longint      ng;
            a  = $urandom;
            s  = (($urandom % 8) == 0) ? 32'd0 : ($urandom % 300);
            ng = (longint'(a[4:0]) + longint'(s) + 31) >> 5;
            if (ng < 1) ng = 1;
            m_code      = (($urandom % 2) == 0) ? 4'd12 : 4'($urandom % 16);
            m_bad_en    = ($urandom % 2) == 1;
            m_bad_addr  = {a[31:5], 5'd0} + 32'(32 * ($urandom % ng));
            m_bad_code  = 4'($urandom % 16);
            m_bad_valid = 2'($urandom % 4);
            run(a, s, ($urandom % 2) == 1, ($urandom % 2) == 1, 1'b0, "R5 R6 R7");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule